// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial data line into characters. It runs on the system clock. A one-cycle enable, `rx_tick`, marks each rising edge of the receive clock, and that clock runs at either one or sixteen times the bit rate. Software-facing logic outside the block sets the character format: five to eight data bits sent least significant bit first, no, even or odd parity, and one, one-and-a-half or two stop bits.

In the sixteen-times mode the receiver screens out short low pulses that are not real start bits. It also re-aligns its bit phase on every accepted line transition, so it samples near the middle of each bit even when the sender's bit period differs somewhat from sixteen ticks. In the one-times mode every tick is taken as one bit, and bit alignment must come from outside the block.

Each finished character goes into a holding register together with its parity and framing flags, and a one-cycle ready strobe is raised. While that character waits for `rd_ack`, the next one is already being shifted in. If a character finishes while the holding register is still occupied, it is dropped and an overrun flag is raised.

Top module: `async_char_rx`

## Requirements
- R1: `cfg_len` selects the data bit count (0 = five, 1 = six, 2 = seven, 3 = eight). Data bits arrive least significant first and fill `rx_data` from bit 0 upward. With parity off, every bit above the data bits reads zero.
- R2: `cfg_par` selects parity (0 = none, 1 = even, 2 = odd, 3 = none). With parity on, `rx_par_err` is 1 when the received parity bit does not give the chosen parity over the data bits. With parity off, `rx_par_err` is always 0.
- R3: With parity on and fewer than eight data bits, `rx_data` carries the received parity bit at the position just above the last data bit, and zeros above that. With eight data bits, the parity bit does not appear in `rx_data`.
- R4: `rx_frm_err` is 1 when the first stop bit is sampled low.
- R5: In sixteen-times mode (`cfg_x16` = 1), a low level counts as a start only if it is seen on three consecutive ticks. A shorter low pulse produces no character.
- R6: In sixteen-times mode, after those three ticks the line must stay low for eight more ticks, eleven ticks in all. Otherwise the start is discarded and no character is produced. A low of ten ticks is discarded.
- R7: In sixteen-times mode, the phase count restarts at zero on a line transition only once the count has reached four, and each bit is sampled when the count reaches eight. A character whose bits last fourteen ticks each is therefore received correctly.
- R8: In one-times mode (`cfg_x16` = 0), the first low tick is the start bit, and each following tick is one bit.
- R9: `cfg_stop` selects the stop setting (0 = one, 1 = one-and-a-half, 2 = two). After the first stop sample, the line is ignored for 0, 8 or 16 ticks in sixteen-times mode, or for 0, 1 or 1 ticks in one-times mode, before start hunting resumes.
- R10: A finished character is loaded into the holding register and `rx_ready` pulses for one cycle. `rx_full` then stays 1, and `rx_data` and the error flags stay unchanged, until `rd_ack` clears `rx_full`.
- R11: A character that finishes while `rx_full` is 1, with no `rd_ack` in the same cycle, is dropped: `rx_ovr_err` is set and the held data stay. `rd_ack` clears `rx_ovr_err`. If `rd_ack` arrives in the same cycle, the new character is loaded.
- R12: After reset, `rx_data`, `rx_ready`, `rx_full` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | One-cycle enable, one per receive-clock rising edge |
| rx_line | input | 1 | Serial data line, already synchronised, idles high |
| cfg_x16 | input | 1 | 1 = sixteen ticks per bit, 0 = one tick per bit |
| cfg_len | input | 2 | Data bit count minus five |
| cfg_par | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop | input | 2 | Stop setting: 0 one, 1 one-and-a-half, 2 two |
| rd_ack | input | 1 | Consumes the held character and clears overrun |
| rx_data | output | 8 | Held character byte |
| rx_ready | output | 1 | One-cycle strobe when a character is loaded |
| rx_full | output | 1 | Holding register occupied |
| rx_par_err | output | 1 | Parity error of the held character |
| rx_frm_err | output | 1 | Framing error of the held character |
| rx_ovr_err | output | 1 | A character was dropped while the register was full |

## Verification
The bench uses the package defaults: sixteen ticks per bit, a start window that ends at tick ten, and stop tails of eight and sixteen ticks. These defaults let it place a low pulse exactly one tick short of an accepted start, and hide a near-valid start inside the two-stop tail. A fourteen-tick bit period stays within reach of the resynchronisation rule but goes out of range without it. The one-times mode is exercised with the same table, so the format logic is covered under both tick rates.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int OVS          = 16;
    localparam int PH_W         = $clog2(OVS);
    localparam int SAMPLE_PH    = OVS / 2;
    localparam int CHECK_PH     = OVS / 4;
    localparam int STABLE_EDGES = 3;
    localparam int GUARD_EDGES  = OVS / 2;
    localparam int START_LAST   = STABLE_EDGES + GUARD_EDGES - 1;
    localparam int MAX_BITS     = 8;
    localparam int MIN_BITS     = 5;
    localparam int BI_W         = $clog2(MAX_BITS);
    localparam int IDX_W        = $clog2(MAX_BITS + 3);
    localparam int TAIL_W       = $clog2(OVS + 1);

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_RSV      = 2'd3
    } stop_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_RUN,
        ST_TAIL
    } tstate_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                par_err;
        logic                frm_err;
    } rx_char_t;

    function automatic logic [IDX_W-1:0] data_bits(input logic [1:0] len);
        return IDX_W'(MIN_BITS) + IDX_W'(len);
    endfunction

    function automatic logic par_on(input par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic [TAIL_W-1:0] tail_ticks(input stop_e s, input logic x16);
        logic [TAIL_W-1:0] t;
        t = '0;
        if (x16) begin
            if (s == STOP_ONE_HALF)  t = TAIL_W'(OVS / 2);
            else if (s == STOP_TWO)  t = TAIL_W'(OVS);
        end else if (s == STOP_ONE_HALF || s == STOP_TWO) begin
            t = TAIL_W'(1);
        end
        return t;
    endfunction

endpackage

// File: rtl/srx_timing.sv
module srx_timing
    import srx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  line,
    input  logic  x16,
    input  stop_e stop_sel,
    input  logic  at_last,
    output logic  start_ok,
    output logic  bit_stb,
    output logic  bit_val
);

    tstate_e            st, st_n;
    logic [PH_W-1:0]    ph, ph_n, ph_inc;
    logic [TAIL_W-1:0]  tl, tl_n, tl_load;
    logic               line_q;
    logic               edge_seen;

    always_comb begin
        st_n     = st;
        ph_n     = ph;
        tl_n     = tl;
        start_ok = 1'b0;
        bit_stb  = 1'b0;
        bit_val  = line;
        ph_inc   = ph + 1'b1;
        edge_seen = (line != line_q);
        tl_load  = tail_ticks(stop_sel, x16);
        if (tick) begin
            unique case (st)
                ST_HUNT: begin
                    if (!line) begin
                        ph_n = '0;
                        if (x16) begin
                            st_n = ST_START;
                        end else begin
                            st_n     = ST_RUN;
                            start_ok = 1'b1;
                        end
                    end
                end
                ST_START: begin
                    if (line) begin
                        st_n = ST_HUNT;
                    end else begin
                        ph_n = ph_inc;
                        if (ph_inc == PH_W'(START_LAST)) begin
                            st_n     = ST_RUN;
                            start_ok = 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (x16) begin
                        if (edge_seen && (ph_inc >= PH_W'(CHECK_PH))) begin
                            ph_n = '0;
                        end else begin
                            ph_n    = ph_inc;
                            bit_stb = (ph_inc == PH_W'(SAMPLE_PH));
                        end
                    end else begin
                        bit_stb = 1'b1;
                    end
                    if (bit_stb && at_last) begin
                        if (tl_load == '0) begin
                            st_n = ST_HUNT;
                        end else begin
                            st_n = ST_TAIL;
                            tl_n = tl_load;
                        end
                    end
                end
                ST_TAIL: begin
                    tl_n = tl - 1'b1;
                    if (tl == TAIL_W'(1)) st_n = ST_HUNT;
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HUNT;
            ph     <= '0;
            tl     <= '0;
            line_q <= 1'b1;
        end else begin
            st <= st_n;
            ph <= ph_n;
            tl <= tl_n;
            if (tick) line_q <= line;
        end
    end

    // R5: a start is only ever accepted while the line is low
    p_start_from_low_r5: assert property (@(posedge clk) disable iff (rst)
        start_ok |-> !line);

    // R7: a start acceptance and a bit sample never share a tick
    p_no_dual_event_r7: assert property (@(posedge clk) disable iff (rst)
        !(start_ok && bit_stb));

    // R9: the stop tail neither samples nor starts
    p_tail_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TAIL) |-> (!bit_stb && !start_ok));

endmodule

// File: rtl/srx_assemble.sv
module srx_assemble
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_ok,
    input  logic       bit_stb,
    input  logic       bit_val,
    input  logic [1:0] len_sel,
    input  par_e       par_sel,
    output logic       at_last,
    output logic       done,
    output rx_char_t   chr
);

    logic [IDX_W-1:0]    idx, dbits, last;
    logic [MAX_BITS-1:0] dat;
    logic                pbit, pen, exp_p;
    rx_char_t            built;

    always_comb begin
        dbits   = data_bits(len_sel);
        pen     = par_on(par_sel);
        last    = dbits + IDX_W'(pen);
        at_last = (idx == last);
        exp_p   = (par_sel == PAR_ODD) ? ~(^dat) : (^dat);
        built.data = dat;
        if (pen && (dbits < IDX_W'(MAX_BITS))) built.data[dbits[BI_W-1:0]] = pbit;
        built.par_err = pen && (pbit != exp_p);
        built.frm_err = !bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            dat  <= '0;
            pbit <= 1'b0;
            done <= 1'b0;
            chr  <= '0;
        end else begin
            done <= 1'b0;
            if (start_ok) begin
                idx  <= '0;
                dat  <= '0;
                pbit <= 1'b0;
            end else if (bit_stb) begin
                if (idx < dbits)   dat[idx[BI_W-1:0]] <= bit_val;
                else if (!at_last) pbit <= bit_val;
                if (at_last) begin
                    done <= 1'b1;
                    chr  <= built;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R2: with parity off a finished character never carries a parity error
    p_noparity_clean_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !par_on(par_sel)) |-> !chr.par_err);

    // R1: five-bit characters without parity keep the upper bits clear
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (done && (len_sel == 2'd0) && !par_on(par_sel)) |-> (chr.data[7:5] == 3'b000));

endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  rx_char_t            chr,
    input  logic                rd_ack,
    output logic [MAX_BITS-1:0] data,
    output logic                ready,
    output logic                full,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err
);

    rx_char_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            ready   <= 1'b0;
            full    <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (rd_ack) begin
                full    <= 1'b0;
                ovr_err <= 1'b0;
            end
            if (done) begin
                if (full && !rd_ack) begin
                    ovr_err <= 1'b1;
                end else begin
                    held  <= chr;
                    full  <= 1'b1;
                    ready <= 1'b1;
                end
            end
        end
    end

    assign data    = held.data;
    assign par_err = held.par_err;
    assign frm_err = held.frm_err;

    // R10: the ready strobe lasts one cycle
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R10: an acknowledge with no new character empties the register
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !done) |=> !full);

    // R11: a dropped character leaves the held one untouched and flags overrun
    p_drop_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        (done && full && !rd_ack) |=> (ovr_err && $stable(held)));

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_tick,
    input  logic       rx_line,
    input  logic       cfg_x16,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic [1:0] cfg_stop,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       rx_full,
    output logic       rx_par_err,
    output logic       rx_frm_err,
    output logic       rx_ovr_err
);

    logic     start_ok, bit_stb, bit_val, at_last, done;
    rx_char_t chr;
    par_e     par_sel;
    stop_e    stop_sel;

    assign par_sel  = par_e'(cfg_par);
    assign stop_sel = stop_e'(cfg_stop);

    srx_timing u_timing (
        .clk      (clk),
        .rst      (rst),
        .tick     (rx_tick),
        .line     (rx_line),
        .x16      (cfg_x16),
        .stop_sel (stop_sel),
        .at_last  (at_last),
        .start_ok (start_ok),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val)
    );

    srx_assemble u_assemble (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .len_sel  (cfg_len),
        .par_sel  (par_sel),
        .at_last  (at_last),
        .done     (done),
        .chr      (chr)
    );

    srx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .chr      (chr),
        .rd_ack   (rd_ack),
        .data     (rx_data),
        .ready    (rx_ready),
        .full     (rx_full),
        .par_err  (rx_par_err),
        .frm_err  (rx_frm_err),
        .ovr_err  (rx_ovr_err)
    );

endmodule

// File: tb/async_char_rx_bench.sv
`timescale 1ns/1ps
module async_char_rx_bench;

    typedef struct packed {
        logic       x16;
        logic [1:0] len;
        logic [1:0] par;
        logic [1:0] stop;
        logic [7:0] data;
        logic       bad_par;
        logic       bad_stop;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd3, 2'd0, 2'd0, 8'hA5, 1'b0, 1'b0},
        '{1'b1, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 1'b0},
        '{1'b1, 2'd0, 2'd1, 2'd0, 8'h13, 1'b0, 1'b0},
        '{1'b1, 2'd2, 2'd2, 2'd1, 8'h5A, 1'b0, 1'b0},
        '{1'b1, 2'd3, 2'd1, 2'd2, 8'h81, 1'b1, 1'b0},
        '{1'b1, 2'd1, 2'd0, 2'd0, 8'h2C, 1'b0, 1'b1},
        '{1'b0, 2'd3, 2'd2, 2'd0, 8'h3C, 1'b0, 1'b0},
        '{1'b0, 2'd0, 2'd0, 2'd2, 8'h0B, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       cfg_x16 = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_full, rx_par_err, rx_frm_err, rx_ovr_err;

    int   checks = 0;
    int   fails  = 0;
    int   got_n  = 0;
    logic [7:0] got_data = 8'h00;
    logic got_pe = 1'b0;
    logic got_fe = 1'b0;
    bit   finished = 1'b0;

    async_char_rx u_async_char_rx (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_line(rx_line),
        .cfg_x16(cfg_x16), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready), .rx_full(rx_full),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_ovr_err(rx_ovr_err)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rx_ready) begin
            got_n    = got_n + 1;
            got_data = rx_data;
            got_pe   = rx_par_err;
            got_fe   = rx_frm_err;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n, input logic level);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_line = level;
            rx_tick = 1'b1;
            @(negedge clk);
            rx_tick = 1'b0;
        end
    endtask

    function automatic bit pon(input vec_t v);
        return (v.par == 2'd1) || (v.par == 2'd2);
    endfunction

    function automatic logic [7:0] masked(input vec_t v);
        int n;
        n = 5 + int'(v.len);
        return v.data & (8'hFF >> (8 - n));
    endfunction

    function automatic logic sent_par(input vec_t v);
        logic [7:0] d;
        logic p;
        d = masked(v);
        p = (v.par == 2'd2) ? ~(^d) : (^d);
        return p ^ v.bad_par;
    endfunction

    function automatic logic [7:0] exp_byte(input vec_t v);
        logic [7:0] d;
        int n;
        n = 5 + int'(v.len);
        d = masked(v);
        if (pon(v) && n < 8) d[n] = sent_par(v);
        return d;
    endfunction

    function automatic string vec_req(input int k);
        case (k)
            0, 1:    return "R1";
            2, 3:    return "R3";
            4:       return "R2";
            5:       return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic set_cfg(input vec_t v);
        @(negedge clk);
        cfg_x16  = v.x16;
        cfg_len  = v.len;
        cfg_par  = v.par;
        cfg_stop = v.stop;
    endtask

    task automatic send_frame(input vec_t v, input int t);
        int n;
        n = 5 + int'(v.len);
        ticks(t, 1'b0);
        for (int i = 0; i < n; i++) ticks(t, v.data[i]);
        if (pon(v)) ticks(t, sent_par(v));
        ticks(t, !v.bad_stop);
        if (v.stop == 2'd1)      ticks((t > 1) ? t / 2 : 1, 1'b1);
        else if (v.stop == 2'd2) ticks(t, 1'b1);
        ticks(2 * t + 6, 1'b1);
    endtask

    task automatic ack;
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vec_t v;
        int   prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "rx_full", int'(rx_full), 0);
        chk("R12", "rx_ready", int'(rx_ready), 0);
        chk("R12", "rx_data", int'(rx_data), 0);
        chk("R12", "errors", int'({rx_par_err, rx_frm_err, rx_ovr_err}), 0);
        ticks(4, 1'b1);

        // table walk over formats and both tick rates
        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            set_cfg(v);
            prev = got_n;
            send_frame(v, v.x16 ? 16 : 1);
            chk("R10", "char count", got_n, prev + 1);
            chk(vec_req(k), "data", int'(got_data), int'(exp_byte(v)));
            chk(vec_req(k), "parity err", int'(got_pe), int'(pon(v) && v.bad_par));
            chk(vec_req(k), "framing err", int'(got_fe), int'(v.bad_stop));
            chk("R10", "full before ack", int'(rx_full), 1);
            ack();
            chk("R10", "full after ack", int'(rx_full), 0);
        end

        v = '{1'b1, 2'd3, 2'd0, 2'd0, 8'hA5, 1'b0, 1'b0};
        set_cfg(v);

        // R5: two-tick low pulse is not a start
        prev = got_n;
        ticks(2, 1'b0);
        ticks(40, 1'b1);
        chk("R5", "short pulse chars", got_n, prev);

        // R6: ten low ticks fall one short of the guard window
        ticks(10, 1'b0);
        ticks(40, 1'b1);
        chk("R6", "guard violation chars", got_n, prev);

        // R5: hunting still works after the rejected starts
        send_frame(v, 16);
        chk("R5", "frame after false starts", int'(got_data), 8'hA5);
        chk("R5", "count after false starts", got_n, prev + 1);
        ack();

        // R7: fourteen-tick bits recovered through resynchronisation
        v.data = 8'h55;
        prev = got_n;
        send_frame(v, 14);
        chk("R7", "skewed count", got_n, prev + 1);
        chk("R7", "skewed data", int'(got_data), 8'h55);
        chk("R7", "skewed flags", int'({got_pe, got_fe}), 0);
        ack();

        // R9: a near-valid start hidden in the two-stop tail is ignored
        v.stop = 2'd2;
        set_cfg(v);
        prev = got_n;
        ticks(16, 1'b0);
        for (int i = 0; i < 8; i++) ticks(16, 1'b0);
        ticks(16, 1'b1);
        ticks(12, 1'b0);
        ticks(60, 1'b1);
        chk("R9", "tail chars", got_n, prev + 1);
        chk("R9", "tail data", int'(got_data), 8'h00);
        ack();

        // R11: second character while full is dropped
        v.stop = 2'd0;
        set_cfg(v);
        prev = got_n;
        v.data = 8'h11;
        send_frame(v, 16);
        v.data = 8'h22;
        send_frame(v, 16);
        chk("R11", "overrun count", got_n, prev + 1);
        chk("R11", "held data", int'(rx_data), 8'h11);
        chk("R11", "overrun flag", int'(rx_ovr_err), 1);
        chk("R11", "still full", int'(rx_full), 1);
        ack();
        chk("R11", "overrun cleared", int'(rx_ovr_err), 0);
        chk("R10", "empty after ack", int'(rx_full), 0);

        finish_run();
    end

endmodule